// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Block

This block is the register face of a one-time-programmable fuse controller. A host reaches it over a plain 32-bit register bus with separate read and write strobes. It holds a control register that can be written directly or changed through a set alias and a clear alias. It also holds a data register, and a window of shadow words that mirror the fuse array. A small sequencer tracks the two internal operations, which are opening the shadow bank for reading and burning a fuse word. The sequencer drives a busy flag that rises only a few cycles after the command that starts it.

To read fuses, software sets the bank-open bit and waits for busy to come and go. It then reads shadow words at 16-byte spacing. To burn a word, software closes the bank and writes the control register with the fuse index and the unlock key. It then writes the bit mask to the data register. After the lag and a fixed busy window, the mask is ORed into the stored word, because fuse bits only go from 0 to 1. A read or program attempt that breaks these rules sets a sticky error flag. Only the clear alias removes that flag.

The sequencer has five states. `ST_IDLE` moves to `ST_OPEN_LAG` on an open request, or to `ST_PROG_LAG` on an accepted program request. Each lag state moves after `LAG_CYC` cycles to its busy state, `ST_OPEN_BUSY` or `ST_PROG_BUSY`. `ST_OPEN_BUSY` returns to `ST_IDLE` after `OPEN_CYC` cycles. `ST_PROG_BUSY` returns to `ST_IDLE` after `PROG_CYC` cycles and burns the word on that last cycle.

Top module: `fuse_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x00000000, the data register reads 0, every shadow word holds 0 and `busy_o` is low.
- R2: Control layout: bits [5:0] hold the fuse index, bit 8 is busy (read-only), bit 9 is error, bit 12 is bank-open, and bits [31:16] hold the key. A write to offset 0x000 loads the index, bank-open and key fields. A write to 0x004 ORs the 1 bits of the write into those fields. A write to 0x008 clears the fields whose bits are 1. Zero bits, and any write to busy through the aliases, change nothing.
- R3: When bank-open goes from 0 to 1 while the sequencer is idle, `busy_o` stays low for `LAG_CYC` cycles after the write edge and then stays high for exactly `OPEN_CYC` cycles.
- R4: The error flag is sticky. Direct writes and set-alias writes leave it unchanged. Only a clear-alias write with bit 9 set clears it.
- R5: Shadow word n is read at offset 0x100 + (n << 4), where n = (bank << 3) | word, with 5 banks of 8 words. An unaligned offset in the window, or an offset past word 39, reads 0 and sets no error.
- R6: A shadow read while bank-open is 1 and the sequencer is idle returns the stored fuse word.
- R7: A shadow read while bank-open is 0, or while an operation is in its lag or busy phase, returns 0xDEAD0F0F and sets the error flag.
- R8: A data write only requests programming when the key field holds 0x3E77. Otherwise it changes no fuse word, does not raise busy and sets no error.
- R9: An accepted program request keeps `busy_o` low for `LAG_CYC` cycles, then high for exactly `PROG_CYC` cycles. The data mask is then ORed into the indexed fuse word.
- R10: A keyed data write is refused if bank-open is 1, if an operation is in progress, or if the index is 40 or more. A refused write sets the error flag, starts nothing and leaves the fuse words unchanged.
- R11: The data register at 0x010 reads back the last value written. Every read returns its data with `bus_rvalid` one cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| busy_o | output | 1 | Sequencer busy phase |

## Verification
The bench samples `busy_o` on every cycle after an open or program command. A design that raised busy on the write edge, or that used the wrong lag or window length, fails the cycle-exact count. It burns two masks into one word and checks that the result is their OR; a design that overwrites the word loses the first mask. It attempts programs with no key, with the wrong key, with the bank open, with an index out of range and during a running operation, then reads the shadow words back. Any of these leaking through would change a word. It also tries to clear the error flag by direct and set-alias writes, which a non-sticky flag would fail. Finally it reads shadow words with the bank closed and during the lag phase, and expects the sentinel value.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN_LAG,
        ST_OPEN_BUSY,
        ST_PROG_LAG,
        ST_PROG_BUSY
    } seq_state_t;

    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_SET    = 12'h004;
    localparam logic [11:0] OFS_CLR    = 12'h008;
    localparam logic [11:0] OFS_DATA   = 12'h010;
    localparam logic [11:0] OFS_SHADOW = 12'h100;

    localparam int CB_BUSY = 8;
    localparam int CB_ERR  = 9;
    localparam int CB_OPEN = 12;
    localparam int KEY_LSB = 16;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [31:0] SENTINEL   = 32'hDEAD0F0F;

endpackage

// File: rtl/fuse_ctl_seq.sv
module fuse_ctl_seq
    import fuse_ctl_pkg::*;
#(
    parameter int LAG_CYC  = 3,
    parameter int OPEN_CYC = 4,
    parameter int PROG_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_go,
    input  logic prog_go,
    output logic busy,
    output logic idle,
    output logic burn
);
    localparam int MAX_A = (LAG_CYC > OPEN_CYC) ? LAG_CYC : OPEN_CYC;
    localparam int MAXC  = (MAX_A > PROG_CYC) ? MAX_A : PROG_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LAG_LAST  = CW'(LAG_CYC - 1);
    localparam logic [CW-1:0] OPEN_LAST = CW'(OPEN_CYC - 1);
    localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);

    seq_state_t state, nxt;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        nxt   = state;
        cnt_n = cnt + 1'b1;
        unique case (state)
            ST_IDLE: begin
                cnt_n = '0;
                if (open_go)      nxt = ST_OPEN_LAG;
                else if (prog_go) nxt = ST_PROG_LAG;
            end
            ST_OPEN_LAG: begin
                if (cnt == LAG_LAST) begin
                    nxt   = ST_OPEN_BUSY;
                    cnt_n = '0;
                end
            end
            ST_OPEN_BUSY: begin
                if (cnt == OPEN_LAST) begin
                    nxt   = ST_IDLE;
                    cnt_n = '0;
                end
            end
            ST_PROG_LAG: begin
                if (cnt == LAG_LAST) begin
                    nxt   = ST_PROG_BUSY;
                    cnt_n = '0;
                end
            end
            ST_PROG_BUSY: begin
                if (cnt == PROG_LAST) begin
                    nxt   = ST_IDLE;
                    cnt_n = '0;
                end
            end
            default: begin
                nxt   = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        busy = (state == ST_OPEN_BUSY) || (state == ST_PROG_BUSY);
        idle = (state == ST_IDLE);
        burn = (state == ST_PROG_BUSY) && (cnt == PROG_LAST);
    end

endmodule

// File: rtl/fuse_ctl_array.sv
module fuse_ctl_array #(
    parameter int N_FUSE = 40,
    parameter int IDX_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burn,
    input  logic [IDX_W-1:0] burn_idx,
    input  logic [31:0]      burn_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);
    localparam logic [IDX_W:0] LIM = (IDX_W+1)'(N_FUSE);

    logic [31:0] mem [N_FUSE];

    for (genvar g = 0; g < N_FUSE; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (burn && (burn_idx == IDX_W'(g)))
                mem[g] <= mem[g] | burn_mask;
        end
    end

    always_comb begin
        if ({1'b0, rd_idx} < LIM) rd_word = mem[rd_idx];
        else                      rd_word = '0;
    end

endmodule

// File: rtl/fuse_ctl_regs.sv
module fuse_ctl_regs
    import fuse_ctl_pkg::*;
#(
    parameter int BANKS    = 5,
    parameter int WORDS    = 8,
    parameter int LAG_CYC  = 3,
    parameter int OPEN_CYC = 4,
    parameter int PROG_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        busy_o
);
    localparam int N_FUSE = BANKS * WORDS;
    localparam int IDX_W  = $clog2(BANKS) + $clog2(WORDS);
    localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(N_FUSE);
    localparam logic [7:0]     WIN_LIM = 8'(N_FUSE);
    localparam logic [31:0] WMASK = {16'hFFFF, 3'b000, 1'b1, 12'h000}
                                  | {{(32-IDX_W){1'b0}}, {IDX_W{1'b1}}};

    // control state
    logic [31:0] ctl_q, ctl_n;
    logic        err_q, err_n;
    logic [31:0] data_q;
    logic [IDX_W-1:0] tgt_idx;
    logic [31:0]      tgt_mask;

    // decode
    logic wr_ctrl, wr_set, wr_clr, wr_data;
    logic [11:0] sh_off;
    logic [7:0]  sh_slot;
    logic        sh_hit;
    logic [IDX_W-1:0] sh_idx;

    // sequencer handshake
    logic seq_busy, seq_idle, seq_burn;
    logic open_go, prog_try, prog_go, prog_bad, bad_rd;
    logic ctl_open;
    logic [IDX_W-1:0] ctl_idx;
    logic [31:0] sh_word, rd_mux, ctl_view;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
        wr_set  = bus_wr && (bus_addr == OFS_SET);
        wr_clr  = bus_wr && (bus_addr == OFS_CLR);
        wr_data = bus_wr && (bus_addr == OFS_DATA);
        sh_off  = bus_addr - OFS_SHADOW;
        sh_slot = sh_off[11:4];
        sh_hit  = (bus_addr >= OFS_SHADOW) && (sh_off[3:0] == 4'h0)
                  && (sh_slot < WIN_LIM);
        sh_idx  = sh_slot[IDX_W-1:0];
    end

    always_comb begin
        ctl_n = ctl_q;
        if (wr_ctrl)     ctl_n = bus_wdata & WMASK;
        else if (wr_set) ctl_n = ctl_q | (bus_wdata & WMASK);
        else if (wr_clr) ctl_n = ctl_q & ~(bus_wdata & WMASK);
    end

    always_comb begin
        ctl_open = ctl_q[CB_OPEN];
        ctl_idx  = ctl_q[IDX_W-1:0];
        open_go  = !ctl_open && ctl_n[CB_OPEN] && seq_idle;
        prog_try = wr_data && (ctl_q[31:KEY_LSB] == UNLOCK_KEY);
        prog_go  = prog_try && !ctl_open && seq_idle
                   && ({1'b0, ctl_idx} < IDX_LIM);
        prog_bad = prog_try && !prog_go;
        bad_rd   = bus_rd && sh_hit && !(ctl_open && seq_idle);
    end

    always_comb begin
        err_n = err_q;
        if (wr_clr && bus_wdata[CB_ERR]) err_n = 1'b0;
        if (prog_bad || bad_rd)          err_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            err_q    <= 1'b0;
            data_q   <= '0;
            tgt_idx  <= '0;
            tgt_mask <= '0;
        end else begin
            ctl_q <= ctl_n;
            err_q <= err_n;
            if (wr_data) data_q <= bus_wdata;
            if (prog_go) begin
                tgt_idx  <= ctl_idx;
                tgt_mask <= bus_wdata;
            end
        end
    end

    fuse_ctl_seq #(
        .LAG_CYC (LAG_CYC),
        .OPEN_CYC(OPEN_CYC),
        .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_go(open_go),
        .prog_go(prog_go),
        .busy   (seq_busy),
        .idle   (seq_idle),
        .burn   (seq_burn)
    );

    fuse_ctl_array #(
        .N_FUSE(N_FUSE),
        .IDX_W (IDX_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .burn     (seq_burn),
        .burn_idx (tgt_idx),
        .burn_mask(tgt_mask),
        .rd_idx   (sh_idx),
        .rd_word  (sh_word)
    );

    always_comb begin
        ctl_view = ctl_q;
        ctl_view[CB_BUSY] = seq_busy;
        ctl_view[CB_ERR]  = err_q;
        if ((bus_addr == OFS_CTRL) || (bus_addr == OFS_SET) || (bus_addr == OFS_CLR))
            rd_mux = ctl_view;
        else if (bus_addr == OFS_DATA)
            rd_mux = data_q;
        else if (sh_hit)
            rd_mux = (ctl_open && seq_idle) ? sh_word : SENTINEL;
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

    assign busy_o = seq_busy;

endmodule

// File: rtl/fuse_ctl_sva.sv
module fuse_ctl_sva
    import fuse_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        busy_o,
    input logic        err_q,
    input logic        ctl_open,
    input logic        open_go,
    input logic        prog_go
);
    p_open_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        open_go |=> !busy_o);

    p_prog_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> !busy_o);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(bus_wr && (bus_addr == OFS_CLR) && bus_wdata[CB_ERR])) |=> err_q);

    p_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> (!ctl_open && !busy_o));

    p_closed_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFS_SHADOW) && !ctl_open)
        |=> (bus_rvalid && (bus_rdata == SENTINEL) && err_q));

    p_rd_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

endmodule

bind fuse_ctl_regs fuse_ctl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .busy_o    (busy_o),
    .err_q     (err_q),
    .ctl_open  (ctl_open),
    .open_go   (open_go),
    .prog_go   (prog_go)
);

// File: tb/fuse_ctl_regs_test.sv
module fuse_ctl_regs_test;
    localparam int LAG  = 3;
    localparam int OPN  = 4;
    localparam int PRG  = 16;
    localparam logic [31:0] SENT = 32'hDEAD0F0F;
    localparam logic [31:0] KEY  = 32'h3E770000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        busy_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_exp;
    string       m_tag;

    always #2 clk = ~clk;

    fuse_ctl_regs #(.LAG_CYC(LAG), .OPEN_CYC(OPN), .PROG_CYC(PRG)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .busy_o(busy_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle_busy(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            check(tag, {31'b0, busy_o}, 32'h0);
            @(negedge clk);
        end
    endtask

    // called right after the starting write; checks lag then window length
    task automatic chk_lag(input int win, input string tag);
        int cnt;
        for (int k = 0; k < LAG; k++) begin
            check({tag, " lag"}, {31'b0, busy_o}, 32'h0);
            @(negedge clk);
        end
        check({tag, " rise"}, {31'b0, busy_o}, 32'h1);
        cnt = 0;
        while (busy_o && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        check({tag, " window"}, cnt, win);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11: unexpected rvalid rdata=%h expected none", bus_rdata);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                check(m_tag, bus_rdata, m_exp);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'b0, busy_o}, 32'h0);
        rd(12'h000, 32'h0, "R1 ctrl");
        rd(12'h010, 32'h0, "R1 data");
        // R2 aliases
        wr(12'h004, KEY | 32'h5);
        rd(12'h000, KEY | 32'h5, "R2 set");
        wr(12'h004, 32'h2);
        rd(12'h000, KEY | 32'h7, "R2 set or");
        wr(12'h008, 32'h1);
        rd(12'h000, KEY | 32'h6, "R2 clr");
        wr(12'h008, 32'h0);
        rd(12'h000, KEY | 32'h6, "R2 clr zero");
        wr(12'h004, 32'h100);
        check("R2 busy write ignored", {31'b0, busy_o}, 32'h0);
        rd(12'h004, KEY | 32'h6, "R2 set busy ignored");
        // R8 no key / wrong key
        wr(12'h008, 32'hFFFF0000);
        wr(12'h010, 32'h000000F0);
        idle_busy(6, "R8 no key busy");
        rd(12'h010, 32'h000000F0, "R11 data readback");
        rd(12'h000, 32'h6, "R8 no key no error");
        wr(12'h000, 32'h12340006);
        wr(12'h010, 32'h00000001);
        idle_busy(6, "R8 wrong key busy");
        rd(12'h000, 32'h12340006, "R8 wrong key no error");
        // R9 program and OR
        wr(12'h000, KEY | 32'h6);
        wr(12'h010, 32'h000000F0);
        chk_lag(PRG, "R9 prog");
        wr(12'h010, 32'h0F000003);
        chk_lag(PRG, "R9 prog2");
        // R3 open
        wr(12'h004, 32'h1000);
        chk_lag(OPN, "R3 open");
        rd(12'h160, 32'h0F0000F3, "R9 or result");
        rd(12'h100, 32'h0, "R6 word0");
        rd(12'h000, KEY | 32'h1006, "R6 no error");
        // R10 open refusal, R4 sticky
        wr(12'h010, 32'h5);
        idle_busy(4, "R10 open refused busy");
        rd(12'h000, KEY | 32'h1206, "R10 open refused error");
        wr(12'h000, KEY | 32'h1006);
        rd(12'h000, KEY | 32'h1206, "R4 direct write keeps");
        wr(12'h004, 32'h200);
        wr(12'h000, KEY | 32'h1006);
        rd(12'h000, KEY | 32'h1206, "R4 set keeps");
        wr(12'h008, 32'h200);
        rd(12'h000, KEY | 32'h1006, "R4 clr clears");
        // R7 read during lag, read while closed
        wr(12'h008, 32'h1000);
        wr(12'h004, 32'h1000);
        rd(12'h160, SENT, "R7 during lag");
        repeat (10) @(negedge clk);
        rd(12'h000, KEY | 32'h1206, "R7 lag error");
        wr(12'h008, 32'h200);
        wr(12'h008, 32'h1000);
        rd(12'h160, SENT, "R7 closed");
        rd(12'h000, KEY | 32'h0206, "R7 closed error");
        wr(12'h008, 32'h200);
        // R10 index range, then program word 39
        wr(12'h000, KEY | 32'h28);
        wr(12'h010, 32'h1);
        idle_busy(4, "R10 range busy");
        rd(12'h000, KEY | 32'h0228, "R10 range error");
        wr(12'h008, 32'h200);
        wr(12'h000, KEY | 32'h27);
        wr(12'h010, 32'h80000001);
        chk_lag(PRG, "R9 prog39");
        // R10 program during lag
        wr(12'h000, KEY | 32'h1);
        wr(12'h010, 32'h10);
        wr(12'h010, 32'h100);
        repeat (LAG + PRG + 4) @(negedge clk);
        rd(12'h000, KEY | 32'h0201, "R10 busy refused error");
        wr(12'h008, 32'h200);
        // read back all targets
        wr(12'h004, 32'h1000);
        chk_lag(OPN, "R3 open2");
        rd(12'h370, 32'h80000001, "R5 bank4 word7");
        rd(12'h180, 32'h0, "R5 bank1 word0");
        rd(12'h110, 32'h10, "R10 busy refused word");
        rd(12'h160, 32'h0F0000F3, "R8 R10 word6 untouched");
        rd(12'h168, 32'h0, "R5 unaligned");
        rd(12'h380, 32'h0, "R5 past end");
        rd(12'h000, KEY | 32'h1001, "R5 no error");
        repeat (3) @(negedge clk);
        check("R11 all reads answered", exp_q.size(), 32'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule